// File: doc/BRIEF.md
# Programmable RTC Tick Interrupt Timer

This block produces a periodic tick interrupt for a real-time clock. It runs on the 32.768 kHz reference clock. A free-running prescaler divides that clock by a power of two chosen in software. A reloadable down-counter consumes the divided enables. Each time the count runs out, the counter raises a sticky pending flag and reloads itself from a software-programmed value, so the tick rate is `32768 / (2^sel * reload)` Hz.

Software reaches four word registers through a simple write/read port:

| Offset | Register |
|--------|----------|
| 0 | control |
| 1 | reload |
| 2 | live count |
| 3 | pending flag |

Control writes start and stop the counter on changes of the enable bits, not on their levels. This lets a driver rewrite the control word without restarting a running timer. The pending flag drives the interrupt line and is cleared by writing a one to it.

Top module: `rtc_tick_timer`

## Requirements
- R1: After reset, every register reads as zero, `tick_irq` is low and the counter is stopped.
- R2: Control bits [7:4] hold a selector `sel`. The counter steps down once every 2^sel reference cycles, so two successive expirations are `reload * 2^sel` cycles apart.
- R3: A write to the reload register (offset 1) is kept only when its low CNT_W bits exceed 2. Any other write leaves the stored value unchanged.
- R4: The counter loads the stored reload value and starts only on a control write that meets all three conditions:
  - bit 0 (master enable) is 1 in the written value;
  - bit 8 (tick enable) changes from 0 to 1;
  - the stored reload value is nonzero.

  A write that sets bit 8 with bit 0 at 0, or that leaves bit 8 at 1, does not start or reload the counter.
- R5: Either of the following control writes freezes the count:
  - bit 8 changes from 1 to 0 while bit 0 of the written value is 1;
  - bit 0 changes from 1 to 0.
- R6: When the count runs out, pending bit 0 is set, `tick_irq` goes high, and the counter reloads and keeps running.
- R7: Writing 1 to pending bit 0 (offset 3) clears it and lowers `tick_irq`. Writing 0 there has no effect. An expiration in the same cycle as a clear wins.
- R8: The live count reads at offset 2 and falls by one per divided enable while running.
- R9: Reads return data one cycle after `rd_en`. The control register reads back only bits 0, 7:4 and 8; all other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32.768 kHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Word offset of the register |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |
| tick_irq | output | 1 | Tick interrupt, equal to pending bit 0 |

## Verification
The interval between expirations is measured for four (selector, reload) pairs: (0,5), (1,4), (2,3) and (3,6). These pairs separate an off-by-one in the reload count from an error in the prescaler's power of two. The live count is read twice at a known spacing at full rate, which shows that it steps once per enable. The control sequences drive each kind of edge in turn:
- a master-enable fall;
- a tick-enable fall;
- a tick-enable rise with the master bit clear;
- a rewrite with tick enable already set;
- a start attempt with a zero reload.

Each sequence shows whether the start and stop logic follows edges or levels. Writes of 0 and 1 to the pending flag while a long period runs show that the flag is sticky.

// File: rtl/rtc_tick_pkg.sv
package rtc_tick_pkg;

  localparam int REG_AW     = 2;
  localparam int SEL_W      = 4;
  localparam int RELOAD_MIN = 3;

  // Word offsets of the software registers
  typedef enum logic [REG_AW-1:0] {
    OFF_CTRL   = 2'd0,
    OFF_RELOAD = 2'd1,
    OFF_COUNT  = 2'd2,
    OFF_PEND   = 2'd3
  } reg_off_e;

  // Control field bit positions (fixed, software depends on them)
  localparam int BIT_RTC_EN  = 0;
  localparam int BIT_SEL_LSB = 4;
  localparam int BIT_TICK_EN = 8;

  typedef struct packed {
    logic             tick_en;
    logic [SEL_W-1:0] sel;
    logic             rtc_en;
  } ctrl_t;

endpackage

// File: rtl/rtc_tick_prescaler.sv
module rtc_tick_prescaler
  import rtc_tick_pkg::*;
#(
  parameter int PRE_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  output logic             pulse
);

  logic [PRE_W-1:0] div_q;
  logic [PRE_W-1:0] mask;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + PRE_W'(1);
  end

  // Low sel bits all ones: one enable every 2^sel cycles (every cycle for sel=0)
  always_comb begin
    mask  = (PRE_W'(1) << sel) - PRE_W'(1);
    pulse = ((div_q & mask) == mask);
  end

endmodule

// File: rtl/rtc_tick_counter.sv
module rtc_tick_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             stop,
  input  logic             pulse,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count_q,
  output logic             running_q,
  output logic             expire
);

  logic last_step;

  always_comb begin
    last_step = (count_q <= CNT_W'(1));
    expire    = running_q && pulse && !start && !stop && last_step;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q   <= '0;
      running_q <= 1'b0;
    end else if (start) begin
      count_q   <= reload;
      running_q <= 1'b1;
    end else if (stop) begin
      running_q <= 1'b0;
    end else if (running_q && pulse) begin
      count_q <= last_step ? reload : count_q - CNT_W'(1);
    end
  end

endmodule

// File: rtl/rtc_tick_regs.sv
module rtc_tick_regs
  import rtc_tick_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CNT_W-1:0]  count,
  input  logic              expire,
  output ctrl_t             ctrl_q,
  output logic [CNT_W-1:0]  reload_q,
  output logic              start_p,
  output logic              stop_p,
  output logic [DATA_W-1:0] rd_data,
  output logic              tick_irq
);

  ctrl_t            ctrl_new;
  logic             wr_ctrl, wr_reload, wr_pend;
  logic [CNT_W-1:0] reload_new;
  logic             pend_q;
  logic [DATA_W-1:0] rd_next;

  always_comb begin
    wr_ctrl    = wr_en && (reg_off_e'(addr) == OFF_CTRL);
    wr_reload  = wr_en && (reg_off_e'(addr) == OFF_RELOAD);
    wr_pend    = wr_en && (reg_off_e'(addr) == OFF_PEND);
    ctrl_new.rtc_en  = wr_data[BIT_RTC_EN];
    ctrl_new.sel     = wr_data[BIT_SEL_LSB +: SEL_W];
    ctrl_new.tick_en = wr_data[BIT_TICK_EN];
    reload_new = wr_data[CNT_W-1:0];
    // Edge-based start/stop against the stored control word
    start_p = wr_ctrl && ctrl_new.rtc_en && ctrl_new.tick_en &&
              !ctrl_q.tick_en && (reload_q != '0);
    stop_p  = wr_ctrl && ((ctrl_new.rtc_en && !ctrl_new.tick_en && ctrl_q.tick_en) ||
                          (!ctrl_new.rtc_en && ctrl_q.rtc_en));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      pend_q   <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_new;
      if (wr_reload && (reload_new >= CNT_W'(RELOAD_MIN))) reload_q <= reload_new;
      if (expire)                      pend_q <= 1'b1;
      else if (wr_pend && wr_data[0])  pend_q <= 1'b0;
    end
  end

  always_comb begin
    rd_next = '0;
    case (reg_off_e'(addr))
      OFF_CTRL: begin
        rd_next[BIT_RTC_EN]              = ctrl_q.rtc_en;
        rd_next[BIT_SEL_LSB +: SEL_W]    = ctrl_q.sel;
        rd_next[BIT_TICK_EN]             = ctrl_q.tick_en;
      end
      OFF_RELOAD: rd_next[CNT_W-1:0] = reload_q;
      OFF_COUNT:  rd_next[CNT_W-1:0] = count;
      OFF_PEND:   rd_next[0]         = pend_q;
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end

  assign tick_irq = pend_q;

  generate
    if (DATA_W > CNT_W) begin : g_unused
      logic unused_wr_hi;
      assign unused_wr_hi = ^wr_data[DATA_W-1:CNT_W];
    end
  endgenerate

endmodule

// File: rtl/rtc_tick_timer.sv
module rtc_tick_timer
  import rtc_tick_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              tick_irq
);

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] count_q;
  logic             running_q;
  logic             start_p, stop_p, pulse, expire;

  rtc_tick_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk   (clk),
    .rst   (rst),
    .sel   (ctrl_q.sel),
    .pulse (pulse)
  );

  rtc_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .start     (start_p),
    .stop      (stop_p),
    .pulse     (pulse),
    .reload    (reload_q),
    .count_q   (count_q),
    .running_q (running_q),
    .expire    (expire)
  );

  rtc_tick_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .count    (count_q),
    .expire   (expire),
    .ctrl_q   (ctrl_q),
    .reload_q (reload_q),
    .start_p  (start_p),
    .stop_p   (stop_p),
    .rd_data  (rd_data),
    .tick_irq (tick_irq)
  );

endmodule

// File: rtl/rtc_tick_timer_sva.sv
module rtc_tick_timer_sva #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [1:0]        addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              tick_irq,
  input logic [CNT_W-1:0]  reload_q,
  input logic [CNT_W-1:0]  count_q,
  input logic              running_q,
  input logic              start_p,
  input logic              stop_p,
  input logic              pulse,
  input logic              expire
);

  logic clr_req;
  assign clr_req = wr_en && (addr == 2'd3) && wr_data[0];

  a_r3_reload_floor: assert property (@(posedge clk) disable iff (rst)
    (reload_q != $past(reload_q)) |-> (reload_q > CNT_W'(2)));

  a_r5_frozen_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!running_q && !start_p) |=> $stable(count_q));

  a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
    (running_q && pulse && !start_p && !stop_p && count_q > CNT_W'(1))
      |=> (count_q == $past(count_q) - CNT_W'(1)));

  a_r6_reload_and_flag: assert property (@(posedge clk) disable iff (rst)
    expire |=> (tick_irq && running_q && count_q == $past(reload_q)));

  a_r7_clear_lowers: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !expire) |=> !tick_irq);

  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (tick_irq && !clr_req) |=> tick_irq);

  a_r4_start_loads: assert property (@(posedge clk) disable iff (rst)
    start_p |=> (running_q && count_q == $past(reload_q)));

endmodule

bind rtc_tick_timer rtc_tick_timer_sva #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_sva (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .addr      (addr),
  .wr_data   (wr_data),
  .tick_irq  (tick_irq),
  .reload_q  (reload_q),
  .count_q   (count_q),
  .running_q (running_q),
  .start_p   (start_p),
  .stop_p    (stop_p),
  .pulse     (pulse),
  .expire    (expire)
);

// File: tb/rtc_tick_timer_tb.sv
module rtc_tick_timer_tb;

  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [1:0]    addr = 2'd0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          tick_irq;

  int cyc = 0;
  int checks = 0;
  int errors = 0;

  rtc_tick_timer u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .tick_irq(tick_irq)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] a, output logic [DW-1:0] d, output int at);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
    at = cyc;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_irq(output int at);
    while (tick_irq !== 1'b1) @(negedge clk);
    at = cyc;
  endtask

  // R1, R4: reset state, and a start attempt with zero reload
  task automatic t_reset;
    logic [DW-1:0] d; int t;
    for (int a = 0; a < 4; a++) begin
      do_read(2'(a), d, t);
      chk("R1 reset register", d, 0);
    end
    chk("R1 reset irq", {31'd0, tick_irq}, 0);
    do_write(2'd0, 32'h101);
    idle(20);
    do_read(2'd2, d, t);
    chk("R4 zero reload no start", d, 0);
    chk("R4 zero reload no irq", {31'd0, tick_irq}, 0);
    do_write(2'd0, 32'h0);
  endtask

  // R3 reload floor, R9 control readback
  task automatic t_reload;
    logic [DW-1:0] d; int t;
    do_write(2'd1, 2);  do_read(2'd1, d, t); chk("R3 reject 2", d, 0);
    do_write(2'd1, 3);  do_read(2'd1, d, t); chk("R3 accept 3", d, 3);
    do_write(2'd1, 1);  do_read(2'd1, d, t); chk("R3 reject 1 keeps old", d, 3);
    do_write(2'd0, 32'hFFFF_FEF0);
    do_read(2'd0, d, t); chk("R9 ctrl readback mask", d, 32'h0F0);
    do_write(2'd0, 32'h0);
  endtask

  // R8, R4: count loaded at start with the slowest divider
  task automatic t_count_slow;
    logic [DW-1:0] d; int t;
    do_write(2'd1, 7);
    do_write(2'd0, 32'h1F1);
    do_read(2'd2, d, t); chk("R4 start loads reload", d, 7);
    do_write(2'd0, 32'h0F1);
    do_read(2'd2, d, t); chk("R8 count readable after stop", d, 7);
    do_write(2'd0, 32'h0);
  endtask

  // R8 live decrement, R5 stops, R4 edge-only start
  task automatic t_edges;
    logic [DW-1:0] a, b; int ta, tb;
    do_write(2'd1, 200);
    do_write(2'd0, 32'h101);
    do_read(2'd2, a, ta);
    do_read(2'd2, b, tb);
    chk("R8 live decrement", a - b, DW'(tb - ta));
    do_write(2'd0, 32'h001);
    do_read(2'd2, a, ta); idle(10); do_read(2'd2, b, tb);
    chk("R5 tick-enable fall freezes", b, a);
    do_write(2'd0, 32'h101);
    idle(5);
    do_write(2'd0, 32'h100);
    do_read(2'd2, a, ta); idle(10); do_read(2'd2, b, tb);
    chk("R5 master fall freezes", b, a);
    do_write(2'd0, 32'h101);
    idle(10);
    do_read(2'd2, b, tb);
    chk("R4 tick already set no restart", b, a);
    do_write(2'd0, 32'h0);
    do_write(2'd0, 32'h100);
    idle(10);
    do_read(2'd2, b, tb);
    chk("R4 tick rise with master clear ignored", b, a);
    do_write(2'd0, 32'h0);
  endtask

  // R2, R6, R7: interval between expirations
  task automatic t_period(input int sel, input int rl);
    int t1, t2;
    do_write(2'd0, 32'h0);
    do_write(2'd3, 32'h1);
    do_write(2'd1, DW'(rl));
    do_write(2'd0, DW'((sel << 4) | 32'h101));
    wait_irq(t1);
    do_write(2'd3, 32'h1);
    chk("R7 clear lowers irq", {31'd0, tick_irq}, 0);
    wait_irq(t2);
    chk("R2 R6 expiry interval", DW'(t2 - t1), DW'(rl << sel));
    do_write(2'd0, 32'h0);
    do_write(2'd3, 32'h1);
  endtask

  // R7: sticky flag, write of 0 ignored
  task automatic t_w1c;
    logic [DW-1:0] d; int t;
    do_write(2'd1, 100);
    do_write(2'd0, 32'h141);
    wait_irq(t);
    do_write(2'd3, 32'h0);
    chk("R7 write 0 keeps irq", {31'd0, tick_irq}, 1);
    do_read(2'd3, d, t); chk("R7 pending still set", d, 1);
    do_write(2'd3, 32'h1);
    do_read(2'd3, d, t); chk("R7 pending cleared", d, 0);
    chk("R7 irq low after clear", {31'd0, tick_irq}, 0);
    do_write(2'd0, 32'h0);
  endtask

  initial begin
    idle(4);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_reload();
    t_count_slow();
    t_edges();
    t_period(0, 5);
    t_period(1, 4);
    t_period(2, 3);
    t_period(3, 6);
    t_w1c();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule